// File: doc/BRIEF.md
# Dual-Path Bus Driver

This block forwards a 12-bit input word to two identical 12-bit output copies. A mode input selects the path. In one mode the block is a transparent buffer, so the outputs follow the inputs in the same cycle. In the other mode the outputs show an internal register that samples the inputs on the rising clock edge.

The register does not load as one word. The eight low-order bits load only when the active-low clock enable is asserted. The four high-order bits load on every rising edge, whatever the enable does. The register keeps loading while the block is in buffer mode. Returning to register mode therefore shows whatever the register captured most recently.

An active-low output enable controls whether the two output copies drive the bus. Each copy comes with its own drive-enable flag. A surrounding pad ring or tri-state wrapper turns the data-plus-enable pair into a real high-impedance bus. A synchronous active-high reset clears the register.

Top module: `dual_path_bus_driver`

## Requirements
- R1: A rising clock edge with `rst` high clears the internal register to zero. In register mode the outputs then read 0x000 until the next load.
- R2: In register mode (`mode_buf` = 0), a rising edge with `clken_n` = 0 loads all twelve bits of `a_in` into the register. The outputs show the new value right after that edge.
- R3: A rising edge with `clken_n` = 1 loads only bits [11:8] of `a_in`. Bits [7:0] of the register keep their previous value.
- R4: In buffer mode (`mode_buf` = 1), the outputs equal `a_in` in the same cycle, with no clock edge needed.
- R5: Both output copies (`y1_*` and `y2_*`) always carry identical data and identical drive-enable flags.
- R6: With `oe_n` = 1, both drive-enable flags are 0 (high impedance). With `oe_n` = 0, both flags are 1. This holds in either mode.
- R7: The register keeps loading while in buffer mode. When `mode_buf` returns to 0, the outputs show the register contents at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the register |
| a_in | input | 12 | Input data word |
| clken_n | input | 1 | Active-low load enable for bits [7:0] |
| mode_buf | input | 1 | 1 = transparent buffer, 0 = registered path |
| oe_n | input | 1 | Active-low output enable for both copies |
| y1_data | output | 12 | Data of output copy 1 |
| y1_en | output | 1 | Drive enable of copy 1 (0 means high impedance) |
| y2_data | output | 12 | Data of output copy 2 |
| y2_en | output | 1 | Drive enable of copy 2 (0 means high impedance) |

## Verification
On every clock edge, the assertions check the following:
- the split load rule: a full load with the enable asserted, and a high-nibble-only load with it deasserted;
- the clearing effect of reset;
- the path selection;
- that the two copies match;
- that the drive flags follow the output enable.

The bench's scenarios cover what only a test sequence can show. It checks that a mid-cycle switch into buffer mode exposes live inputs before any edge. It also checks that switching back exposes a value the register loaded while it was hidden. Its known vector sequence checks the exact merged words that result when the low byte is held across several edges.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;
  localparam int unsigned BD_WIDTH  = 12;
  localparam int unsigned BD_GATED  = 8;
  localparam int unsigned BD_COPIES = 2;

  typedef enum logic {
    PATH_REG = 1'b0,
    PATH_BUF = 1'b1
  } path_sel_e;
endpackage

// File: rtl/bdrv_capture_reg.sv
module bdrv_capture_reg #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned GATED = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Low GATED bits honour the load enable; the remaining bits load every edge.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < GATED) begin : g_gated
      always_ff @(posedge clk) begin
        if (rst)          q[i] <= 1'b0;
        else if (!load_n) q[i] <= d[i];
      end
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= d[i];
      end
    end
  end
endmodule

// File: rtl/bdrv_path_mux.sv
module bdrv_path_mux
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  path_sel_e        sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (sel)
      PATH_BUF: y = live;
      default:  y = held;
    endcase
  end
endmodule

// File: rtl/bdrv_out_copies.sv
module bdrv_out_copies #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned COPIES = 2
) (
  input  logic                          oe_n,
  input  logic [WIDTH-1:0]              d,
  output logic [COPIES-1:0][WIDTH-1:0]  y,
  output logic [COPIES-1:0]             en
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign y[c]  = d;
    assign en[c] = ~oe_n;
  end
endmodule

// File: rtl/dual_path_bus_driver.sv
module dual_path_bus_driver
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BD_WIDTH,
  parameter int unsigned GATED = BD_GATED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic             clken_n,
  input  logic             mode_buf,
  input  logic             oe_n,
  output logic [WIDTH-1:0] y1_data,
  output logic             y1_en,
  output logic [WIDTH-1:0] y2_data,
  output logic             y2_en
);
  localparam int unsigned COPIES = BD_COPIES;

  logic [WIDTH-1:0]             cap_q;
  logic [WIDTH-1:0]             sel_y;
  logic [COPIES-1:0][WIDTH-1:0] cp_y;
  logic [COPIES-1:0]            cp_en;
  path_sel_e                    path;

  assign path = mode_buf ? PATH_BUF : PATH_REG;

  bdrv_capture_reg #(.WIDTH(WIDTH), .GATED(GATED)) u_cap (
    .clk(clk), .rst(rst), .load_n(clken_n), .d(a_in), .q(cap_q)
  );

  bdrv_path_mux #(.WIDTH(WIDTH)) u_mux (
    .sel(path), .live(a_in), .held(cap_q), .y(sel_y)
  );

  bdrv_out_copies #(.WIDTH(WIDTH), .COPIES(COPIES)) u_out (
    .oe_n(oe_n), .d(sel_y), .y(cp_y), .en(cp_en)
  );

  assign y1_data = cp_y[0];
  assign y1_en   = cp_en[0];
  assign y2_data = cp_y[1];
  assign y2_en   = cp_en[1];
endmodule

// File: rtl/dual_path_bus_driver_chk.sv
module dual_path_bus_driver_chk #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned GATED = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic             clken_n,
  input logic             mode_buf,
  input logic             oe_n,
  input logic [WIDTH-1:0] y1_data,
  input logic             y1_en,
  input logic [WIDTH-1:0] y2_data,
  input logic             y2_en,
  input logic [WIDTH-1:0] reg_q
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_q == '0));

  a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
    !clken_n |=> (reg_q == $past(a_in)));

  a_r3_split_load: assert property (@(posedge clk) disable iff (rst)
    clken_n |=> ((reg_q[GATED-1:0] == $past(reg_q[GATED-1:0])) &&
                 (reg_q[WIDTH-1:GATED] == $past(a_in[WIDTH-1:GATED]))));

  a_r4_buffer_path: assert property (@(posedge clk) disable iff (rst)
    mode_buf |-> (y1_data == a_in));

  a_r5_copies_match: assert property (@(posedge clk) disable iff (rst)
    (y1_data == y2_data) && (y1_en == y2_en));

  a_r6_drive_flag: assert property (@(posedge clk) disable iff (rst)
    (y1_en != oe_n) && (y2_en != oe_n));

  a_r7_register_path: assert property (@(posedge clk) disable iff (rst)
    !mode_buf |-> (y2_data == reg_q));
endmodule

bind dual_path_bus_driver dual_path_bus_driver_chk #(.WIDTH(WIDTH), .GATED(GATED)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .clken_n(clken_n), .mode_buf(mode_buf),
  .oe_n(oe_n), .y1_data(y1_data), .y1_en(y1_en), .y2_data(y2_data),
  .y2_en(y2_en), .reg_q(cap_q)
);

// File: tb/dual_path_bus_driver_bench.sv
`timescale 1ns/1ps
module dual_path_bus_driver_bench;
  localparam int NV = 8;
  // control per vector: {mode_buf, clken_n, oe_n}
  localparam logic [2:0]  CTL [NV] = '{3'b000, 3'b010, 3'b010, 3'b001,
                                       3'b110, 3'b100, 3'b010, 3'b000};
  localparam logic [11:0] AIN [NV] = '{12'hABC, 12'h123, 12'hFFF, 12'h5A5,
                                       12'h3C3, 12'hE01, 12'h777, 12'h000};
  localparam logic [11:0] EXP [NV] = '{12'hABC, 12'h1BC, 12'hFBC, 12'h5A5,
                                       12'h3C3, 12'hE01, 12'h701, 12'h000};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_in = '0;
  logic        clken_n = 1'b1;
  logic        mode_buf = 1'b0;
  logic        oe_n = 1'b0;
  logic [11:0] y1_data, y2_data;
  logic        y1_en, y2_en;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  dual_path_bus_driver u_dual_path_bus_driver (
    .clk(clk), .rst(rst), .a_in(a_in), .clken_n(clken_n), .mode_buf(mode_buf),
    .oe_n(oe_n), .y1_data(y1_data), .y1_en(y1_en), .y2_data(y2_data), .y2_en(y2_en)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset clears the register, seen in register mode
    a_in = 12'hFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset value", y1_data, 12'h000);
    check("R6 enabled flag", {11'd0, y1_en}, 12'h001);

    // Vector table walk: inputs at negedge, outputs sampled 1ns after posedge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_buf = CTL[i][2];
      clken_n  = CTL[i][1];
      oe_n     = CTL[i][0];
      a_in     = AIN[i];
      @(posedge clk);
      #1;
      check($sformatf("R2/R3/R4 vec%0d y1", i), y1_data, EXP[i]);
      check($sformatf("R5 vec%0d y2", i), y2_data, EXP[i]);
      check($sformatf("R6 vec%0d en", i), {10'd0, y2_en, y1_en},
            CTL[i][0] ? 12'h000 : 12'h003);
    end

    // R4/R7: mode switches with no clock edge in between
    @(negedge clk);
    mode_buf = 1'b0; clken_n = 1'b0; oe_n = 1'b0; a_in = 12'h9F3;
    @(posedge clk);
    #1;
    check("R2 load before switch", y1_data, 12'h9F3);
    @(negedge clk);
    mode_buf = 1'b1; clken_n = 1'b1; a_in = 12'h246;
    #1;
    check("R4 live inputs at once", y1_data, 12'h246);
    mode_buf = 1'b0;
    #1;
    check("R7 held value at once", y2_data, 12'h9F3);

    // R7: register loads while hidden in buffer mode (clken_n high: 2 from a_in, F3 held)
    mode_buf = 1'b1;
    @(posedge clk);
    #1;
    check("R4 buffer after edge", y1_data, 12'h246);
    @(negedge clk);
    mode_buf = 1'b0;
    #1;
    check("R7 hidden load visible", y1_data, 12'h2F3);

    // R1: reset while in buffer mode clears register
    @(negedge clk);
    mode_buf = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; mode_buf = 1'b0;
    #1;
    check("R1 reset in buffer mode", y1_data, 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule